// File: doc/BRIEF.md
# GPIO Register Bank with Set/Clear Access and Mirrored Line Order

This block is a general purpose I/O controller that sits behind a simple single-cycle register port. It owns one bank of `WIDTH` bidirectional lines. Each line has an output value, an output enable and an input level. Software reads the synchronised pin levels through a data register. It changes the output latch one bit at a time with write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. It selects the direction of each line through two direction registers, one where a 1 means output and one where a 1 means input. The block keeps these two registers complementary at all times.

The line-to-bit mapping is fixed at build time. In normal order, line n sits at register bit n. In mirrored order, line n sits at register bit `WIDTH-1-n` in every register. The pins themselves are always indexed by line number. The bus port has no handshake: a write takes effect at the clock edge where `bus_we` is high. `bus_rdata` is registered, so it returns the register selected by `bus_addr` at the previous edge. A read and a write at the same edge return the value from before the write. The port has no valid/ready pair, so there is no back-pressure.

Top module: `gpio_regbank`

## Requirements
- R1: Reading the data register (address 0) returns the level of every line, 1 meaning high, after a two-flop synchroniser; a pin change made just before edge e1 first appears in `bus_rdata` after edge e3 when the data register is read continuously.
- R2: A write to the set register (address 1) sets each output latch bit written with 1; bits written with 0 keep their value.
- R3: A write to the clear register (address 2) clears each output latch bit written with 1; bits written with 0 keep their value.
- R4: Reading the set register returns the output latch value, independent of the pin levels, so a line driven high reads 1 there even while its pin reads 0 in the data register.
- R5: In the output-direction register (address 3), a 1 makes the line an output; `pin_oe` equals the direction bits and `pin_out` equals the output latch, both in line order.
- R6: In the input-direction register (address 4), a 1 makes the line an input; a write to either direction register updates both, so address 4 always reads the bitwise inverse of address 3.
- R7: With `MIRROR`=1, line n maps to register bit `WIDTH-1-n` in all five registers, so line 0 is the most significant bit.
- R8: After reset the output latch is all zeros and every line is an input: `pin_out` and `pin_oe` are 0, address 3 reads 0 and address 4 reads all ones.
- R9: Reads of addresses 5 to 7 return zero; writes to addresses 0 and 5 to 7 change neither the latch nor the direction.
- R10: `bus_rdata` is registered: it shows, one edge after the address is presented, the value the selected register held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, acts at the rising edge |
| bus_wdata | input | WIDTH | Write data in register bit order |
| bus_rdata | output | WIDTH | Registered read data in register bit order |
| pin_in | input | WIDTH | Pin levels by line, asynchronous |
| pin_out | output | WIDTH | Output latch by line |
| pin_oe | output | WIDTH | Output enable by line, 1 drives the pin |

## Verification
The hardest case to reach from the ports is a line driven high whose pin the outside world holds low. In that state, the set register and the data register must disagree. The bench builds this state by programming the latch and the direction through the bus and then holding `pin_in` to a pattern that contradicts the latch. It also exposes the synchroniser latency by reading the data register on three consecutive edges right after a pin change. A second instance built with mirrored order and a narrower width checks that the bit reversal applies to writes, reads and pins alike.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 3;

  // Word addresses of the register file
  typedef enum logic [ADDR_W-1:0] {
    GR_DATA = 3'd0,
    GR_SET  = 3'd1,
    GR_CLR  = 3'd2,
    GR_DOUT = 3'd3,
    GR_DIN  = 3'd4
  } gpio_reg_e;

endpackage

// File: rtl/gpio_bitmap.sv
// Maps between register bit order and line order. Reversal is its own
// inverse, so the same block serves both directions.
module gpio_bitmap #(
  parameter int WIDTH  = 32,
  parameter bit MIRROR = 1'b0
) (
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst
);

  generate
    if (MIRROR) begin : g_rev
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dst[i] = src[WIDTH-1-i];
      end
    end else begin : g_str
      assign dst = src;
    end
  endgenerate

endmodule

// File: rtl/gpio_sync.sv
// Two-stage synchroniser for the asynchronous pin levels.
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_outreg.sv
// Output latch and direction state, both held in line order.
module gpio_outreg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_mask,
  input  logic [WIDTH-1:0] clr_mask,
  input  logic             dir_we,
  input  logic [WIDTH-1:0] dir_val,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      // clear wins over set on the same bit
      latch_q <= (latch_q | set_mask) & ~clr_mask;
      if (dir_we) dir_q <= dir_val;
    end
  end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank #(
  parameter int WIDTH  = 32,
  parameter bit MIRROR = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [gpio_pkg::ADDR_W-1:0] bus_addr,
  input  logic                        bus_we,
  input  logic [WIDTH-1:0]            bus_wdata,
  output logic [WIDTH-1:0]            bus_rdata,
  input  logic [WIDTH-1:0]            pin_in,
  output logic [WIDTH-1:0]            pin_out,
  output logic [WIDTH-1:0]            pin_oe
);
  import gpio_pkg::*;

  logic [WIDTH-1:0] wr_line;
  logic [WIDTH-1:0] lvl_line;
  logic [WIDTH-1:0] latch_line;
  logic [WIDTH-1:0] dir_line;
  logic [WIDTH-1:0] lvl_reg;
  logic [WIDTH-1:0] latch_reg;
  logic [WIDTH-1:0] dir_reg;
  logic [WIDTH-1:0] set_mask;
  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] dir_val;
  logic             dir_we;
  logic [WIDTH-1:0] rd_next;
  logic [WIDTH-1:0] rd_q;
  gpio_reg_e        sel;

  assign sel = gpio_reg_e'(bus_addr);

  gpio_bitmap #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_map_wr (
    .src(bus_wdata), .dst(wr_line));

  gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl_line));

  // write decode, in line order
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    dir_we   = 1'b0;
    dir_val  = '0;
    if (bus_we) begin
      case (sel)
        GR_SET:  set_mask = wr_line;
        GR_CLR:  clr_mask = wr_line;
        GR_DOUT: begin dir_we = 1'b1; dir_val = wr_line;  end
        GR_DIN:  begin dir_we = 1'b1; dir_val = ~wr_line; end
        default: ;
      endcase
    end
  end

  gpio_outreg #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst_n(rst_n),
    .set_mask(set_mask), .clr_mask(clr_mask),
    .dir_we(dir_we), .dir_val(dir_val),
    .latch_q(latch_line), .dir_q(dir_line));

  gpio_bitmap #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_map_lvl (
    .src(lvl_line), .dst(lvl_reg));
  gpio_bitmap #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_map_lat (
    .src(latch_line), .dst(latch_reg));
  gpio_bitmap #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_map_dir (
    .src(dir_line), .dst(dir_reg));

  // read select, register order
  always_comb begin
    case (sel)
      GR_DATA: rd_next = lvl_reg;
      GR_SET:  rd_next = latch_reg;
      GR_DOUT: rd_next = dir_reg;
      GR_DIN:  rd_next = ~dir_reg;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_next;
  end

  assign bus_rdata = rd_q;
  assign pin_out   = latch_line;
  assign pin_oe    = dir_line;

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int WIDTH = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [gpio_pkg::ADDR_W-1:0] bus_addr,
  input logic                        bus_we,
  input logic [WIDTH-1:0]            bus_wdata,
  input logic [WIDTH-1:0]            bus_rdata,
  input logic [WIDTH-1:0]            pin_out,
  input logic [WIDTH-1:0]            pin_oe
);

  // R2: setting bits never lowers the number of driven-high lines
  a_r2_set_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd1) |=> ($countones(pin_out) >= $countones($past(pin_out))));

  // R2: writing all ones to set drives every line high
  a_r2_set_all: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd1 && (&bus_wdata)) |=> (&pin_out));

  // R3: clearing bits never raises the number of driven-high lines
  a_r3_clr_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd2) |=> ($countones(pin_out) <= $countones($past(pin_out))));

  // R3: writing all ones to clear drives every line low
  a_r3_clr_all: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd2 && (&bus_wdata)) |=> (pin_out == '0));

  // R4: set register read carries as many ones as the latch had
  a_r4_set_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd1) |=> ($countones(bus_rdata) == $countones($past(pin_out))));

  // R6: input-direction read is the complement of the output enables
  a_r6_din_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd4) |=> ($countones(bus_rdata) == WIDTH - $countones($past(pin_oe))));

  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > 3'd4) |=> (bus_rdata == '0));

  // R9: writes to data or unmapped addresses leave the outputs alone
  a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == 3'd0 || bus_addr > 3'd4)) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R5: without a write the pins hold
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_regbank gpio_regbank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe));

// File: tb/sim_gpio_regbank.sv
`timescale 1ns/1ps
module sim_gpio_regbank;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // instance under table test: 32 lines, normal order
  logic [2:0]  a0 = '0;
  logic        we0 = 1'b0;
  logic [31:0] wd0 = '0, rd0, pi0 = '0, po0, oe0;
  // second instance: 8 lines, mirrored order
  logic [2:0]  a1 = '0;
  logic        we1 = 1'b0;
  logic [7:0]  wd1 = '0, rd1, pi1 = '0, po1, oe1;

  gpio_regbank #(.WIDTH(32), .MIRROR(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(a0), .bus_we(we0), .bus_wdata(wd0),
    .bus_rdata(rd0), .pin_in(pi0), .pin_out(po0), .pin_oe(oe0));

  gpio_regbank #(.WIDTH(8), .MIRROR(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(a1), .bus_we(we1), .bus_wdata(wd1),
    .bus_rdata(rd1), .pin_in(pi1), .pin_out(po1), .pin_oe(oe1));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr0(input logic [2:0] ad, input logic [31:0] d);
    a0 = ad; wd0 = d; we0 = 1'b1;
    @(posedge clk); @(negedge clk);
    we0 = 1'b0;
  endtask

  task automatic rdv0(input logic [2:0] ad, output logic [31:0] v);
    a0 = ad; we0 = 1'b0;
    @(posedge clk); @(negedge clk);
    v = rd0;
  endtask

  task automatic wr1(input logic [2:0] ad, input logic [7:0] d);
    a1 = ad; wd1 = d; we1 = 1'b1;
    @(posedge clk); @(negedge clk);
    we1 = 1'b0;
  endtask

  task automatic rdv1(input logic [2:0] ad, output logic [7:0] v);
    a1 = ad; we1 = 1'b0;
    @(posedge clk); @(negedge clk);
    v = rd1;
  endtask

  // {write, address, data, expected read}
  localparam int NV = 17;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 3'd1, 32'h0000_00F0, 32'h0},          // R2 set
    {1'b0, 3'd1, 32'h0,         32'h0000_00F0},
    {1'b1, 3'd1, 32'h0000_0F00, 32'h0},          // R2 set keeps others
    {1'b0, 3'd1, 32'h0,         32'h0000_0FF0},
    {1'b1, 3'd2, 32'h0000_0330, 32'h0},          // R3 clear
    {1'b0, 3'd1, 32'h0,         32'h0000_0CC0},
    {1'b1, 3'd3, 32'hFFFF_0000, 32'h0},          // R5 direction
    {1'b0, 3'd3, 32'h0,         32'hFFFF_0000},
    {1'b0, 3'd4, 32'h0,         32'h0000_FFFF},  // R6 complement
    {1'b1, 3'd4, 32'h0000_00FF, 32'h0},          // R6 write via input reg
    {1'b0, 3'd3, 32'h0,         32'hFFFF_FF00},
    {1'b1, 3'd0, 32'h0000_1234, 32'h0},          // R9 data write ignored
    {1'b0, 3'd1, 32'h0,         32'h0000_0CC0},
    {1'b1, 3'd5, 32'hFFFF_FFFF, 32'h0},          // R9 unmapped write
    {1'b0, 3'd5, 32'h0,         32'h0},          // R9 unmapped read
    {1'b0, 3'd1, 32'h0,         32'h0000_0CC0},
    {1'b0, 3'd7, 32'h0,         32'h0}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    check("R8 pin_out", po0, 0);
    check("R8 pin_oe", oe0, 0);
    rdv0(3'd3, v); check("R8 dout", v, 0);
    rdv0(3'd4, v); check("R8 din", v, 32'hFFFF_FFFF);
    rdv0(3'd1, v); check("R8 latch", v, 0);
    rdv1(3'd4, w); check("R8 din mirrored", w, 8'hFF);

    // table walk (R2 R3 R5 R6 R9 R10)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][67]) wr0(VEC[i][66:64], VEC[i][63:32]);
      else begin
        rdv0(VEC[i][66:64], v);
        check($sformatf("R10 vector %0d", i), v, VEC[i][31:0]);
      end
    end

    // R5 pins follow latch and direction
    check("R5 pin_out", po0, 32'h0000_0CC0);
    check("R5 pin_oe", oe0, 32'hFFFF_FF00);

    // R1 synchroniser latency: visible on the third read
    pi0 = 32'hA5A5_0F0F;
    rdv0(3'd0, v); check("R1 edge1 old", v, 0);
    rdv0(3'd0, v); check("R1 edge2 old", v, 0);
    rdv0(3'd0, v); check("R1 edge3 new", v, 32'hA5A5_0F0F);

    // R4 driven value read separately from pin level
    rdv0(3'd1, v); check("R4 latch vs pins", v, 32'h0000_0CC0);
    pi0 = 32'h0;
    repeat (3) rdv0(3'd0, v);
    check("R4 pin low while driven high", v, 0);

    // R10 read in the write cycle sees old value
    a0 = 3'd1; wd0 = 32'h0000_0001; we0 = 1'b1;
    @(posedge clk); @(negedge clk);
    we0 = 1'b0;
    check("R10 read during write", rd0, 32'h0000_0CC0);
    rdv0(3'd1, v); check("R10 read after write", v, 32'h0000_0CC1);

    // R3 clear of all bits, R2 set of all bits
    wr0(3'd2, 32'hFFFF_FFFF); check("R3 clear all", po0, 0);
    wr0(3'd1, 32'hFFFF_FFFF); check("R2 set all", po0, 32'hFFFF_FFFF);

    // R7 mirrored order
    wr1(3'd1, 8'h01); check("R7 set bit0 -> line7", po1, 8'h80);
    rdv1(3'd1, w);    check("R7 set readback", w, 8'h01);
    wr1(3'd3, 8'h03); check("R7 oe mirrored", oe1, 8'hC0);
    rdv1(3'd4, w);    check("R7 din mirrored", w, 8'hFC);
    wr1(3'd2, 8'h01); check("R7 clear mirrored", po1, 8'h00);
    pi1 = 8'h01;
    repeat (3) rdv1(3'd0, w);
    check("R7 data line0 -> bit7", w, 8'h80);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule